// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

This block decides, every clock cycle, which warp of a SIMT pipeline may send its next instruction down the pipe. Warps are interleaved one instruction at a time. While one warp waits for a result, the others fill the issue slots. Because every warp's register context stays resident, moving from one warp to another costs no cycles.

The scheduler keeps a state and a program counter for each warp. A warp is idle until it is launched. Once it is ready, it can be issued. After it issues, it is busy until its single instruction resolves, because there is no branch prediction and no second instruction per warp. The pipeline reports the resolution in one of two ways:

- A writeback, which carries the next PC and can also retire the warp.
- A memory completion, which carries a per-thread hit mask.

If any thread missed, the warp is parked in a memory-waiting state until a refill message names it.

The surrounding fetch, register file, ALUs and cache are not part of the block. They appear only as these handshakes.

Top module: `warp_issue_sched`

## Requirements
- R1: After synchronous reset every warp is idle and `issue_valid` is low.
- R2: A launch naming an idle warp makes it ready. The cycle after launch is sampled, it issues with `issue_pc` equal to the launch PC. A launch naming a warp that is not idle is ignored.
- R3: An issued warp is never issued again until a writeback or a memory completion for it has been accepted.
- R4: A writeback for a busy warp sets its PC to `wb_pc` and makes it ready again. If `wb_exit` is 1, the warp returns to idle instead and issues nothing further.
- R5: A memory completion for a busy warp uses `mem_hit_mask`, where bit i is 1 when thread i hit.
  - If every bit is 1, the warp becomes ready with PC `mem_pc`.
  - Otherwise the warp is parked as memory-waiting with PC `mem_pc` and does not issue.
- R6: A refill naming a memory-waiting warp makes it ready at the next clock edge, so it issues one cycle later. A refill naming a warp in any other state is ignored.
- R7: When several warps are ready, the winner is the first ready warp found scanning upward, with wraparound, from one above the warp that issued last. After reset the scan starts at warp 0.
- R8: In any cycle where no warp is ready, `issue_valid` is low in the following cycle.
- R9: Issue outputs are registered: `issue_valid`, `issue_warp` (binary warp ID) and `issue_pc` change only at a clock edge, one cycle after the warp was ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch request |
| launch_warp | input | WID_W | Warp to launch |
| launch_pc | input | PC_W | Starting PC of the launched warp |
| wb_valid | input | 1 | Writeback of a non-memory instruction |
| wb_warp | input | WID_W | Warp whose instruction wrote back |
| wb_pc | input | PC_W | Next PC of that warp |
| wb_exit | input | 1 | Warp has finished and returns to idle |
| mem_valid | input | 1 | Memory access completed |
| mem_warp | input | WID_W | Warp whose memory access completed |
| mem_hit_mask | input | THREADS | Per-thread hit flags, 1 = hit |
| mem_pc | input | PC_W | Next PC of that warp |
| refill_valid | input | 1 | Miss data returned |
| refill_warp | input | WID_W | Warp whose miss was served |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Issuing warp |
| issue_pc | output | PC_W | PC of the issuing instruction |

## Verification
The bench builds the scheduler with four warps of four threads and 16-bit PCs. With only four warps, the four independent event ports (launch, writeback, memory completion, refill) can each make a different warp ready in the same cycle. All four warps then contend at once. The rotating-priority order, including its wrap past the top warp, can be observed in full over four consecutive issues. The four-bit hit mask keeps the partial-miss case, in which some threads hit and one misses, short to drive.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    WST_IDLE  = 2'd0,
    WST_READY = 2'd1,
    WST_BUSY  = 2'd2,
    WST_PARK  = 2'd3
  } warp_st_e;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int NUM_WARPS = 32,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] req,
  input  logic [WID_W-1:0]     last,
  output logic [NUM_WARPS-1:0] gnt,
  output logic [WID_W-1:0]     gnt_idx,
  output logic                 gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int j;
      j = (int'(last) + k) % NUM_WARPS;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = WID_W'(j);
      end
    end
  end
endmodule

// File: rtl/wis_warp_slot.sv
module wis_warp_slot
  import wis_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch_ev,
  input  logic [PC_W-1:0] launch_pc,
  input  logic            wb_ev,
  input  logic            wb_exit,
  input  logic [PC_W-1:0] wb_pc,
  input  logic            mem_ev,
  input  logic            mem_all_hit,
  input  logic [PC_W-1:0] mem_pc,
  input  logic            refill_ev,
  input  logic            grant,
  output warp_st_e        st,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= WST_IDLE;
      pc <= '0;
    end else begin
      case (st)
        WST_IDLE: if (launch_ev) begin
          st <= WST_READY;
          pc <= launch_pc;
        end
        WST_READY: if (grant) st <= WST_BUSY;
        WST_BUSY: begin
          if (wb_ev) begin
            st <= wb_exit ? WST_IDLE : WST_READY;
            pc <= wb_pc;
          end else if (mem_ev) begin
            st <= mem_all_hit ? WST_READY : WST_PARK;
            pc <= mem_pc;
          end
        end
        WST_PARK: if (refill_ev) st <= WST_READY;
        default: st <= WST_IDLE;
      endcase
    end
  end

  // Grants reach only ready warps and always leave them busy (R3)
  assert_grant_only_ready_R3: assert property (@(posedge clk) disable iff (rst)
    grant |-> st == WST_READY);
  assert_grant_to_busy_R3: assert property (@(posedge clk) disable iff (rst)
    grant |=> st == WST_BUSY);
  // A parked warp stays parked until its refill (R5)
  assert_park_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (st == WST_PARK && !refill_ev) |=> st == WST_PARK);
  // Refill wakes a parked warp at the next edge (R6)
  assert_refill_wakes_R6: assert property (@(posedge clk) disable iff (rst)
    (st == WST_PARK && refill_ev) |=> st == WST_READY);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int THREADS   = 32,
  parameter int PC_W      = 32,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch_valid,
  input  logic [WID_W-1:0]   launch_warp,
  input  logic [PC_W-1:0]    launch_pc,
  input  logic               wb_valid,
  input  logic [WID_W-1:0]   wb_warp,
  input  logic [PC_W-1:0]    wb_pc,
  input  logic               wb_exit,
  input  logic               mem_valid,
  input  logic [WID_W-1:0]   mem_warp,
  input  logic [THREADS-1:0] mem_hit_mask,
  input  logic [PC_W-1:0]    mem_pc,
  input  logic               refill_valid,
  input  logic [WID_W-1:0]   refill_warp,
  output logic               issue_valid,
  output logic [WID_W-1:0]   issue_warp,
  output logic [PC_W-1:0]    issue_pc
);
  warp_st_e                         slot_st [NUM_WARPS];
  logic [NUM_WARPS-1:0][PC_W-1:0]   slot_pc;
  logic [NUM_WARPS-1:0]             ready;
  logic [NUM_WARPS-1:0]             gnt;
  logic [WID_W-1:0]                 gnt_idx;
  logic                             gnt_any;
  logic [WID_W-1:0]                 last_q;
  logic                             all_hit;

  assign all_hit = &mem_hit_mask;

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_slot
    assign ready[i] = (slot_st[i] == WST_READY);
    wis_warp_slot #(.PC_W(PC_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .launch_ev   (launch_valid && launch_warp == WID_W'(i)),
      .launch_pc   (launch_pc),
      .wb_ev       (wb_valid && wb_warp == WID_W'(i)),
      .wb_exit     (wb_exit),
      .wb_pc       (wb_pc),
      .mem_ev      (mem_valid && mem_warp == WID_W'(i)),
      .mem_all_hit (all_hit),
      .mem_pc      (mem_pc),
      .refill_ev   (refill_valid && refill_warp == WID_W'(i)),
      .grant       (gnt[i]),
      .st          (slot_st[i]),
      .pc          (slot_pc[i])
    );
  end

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .req     (ready),
    .last    (last_q),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_pc    <= '0;
      last_q      <= WID_W'(NUM_WARPS - 1);
    end else begin
      issue_valid <= gnt_any;
      if (gnt_any) begin
        issue_warp <= gnt_idx;
        issue_pc   <= slot_pc[gnt_idx];
        last_q     <= gnt_idx;
      end
    end
  end

  // The issued warp is busy while its issue is presented (R3)
  assert_issued_is_busy_R3: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> slot_st[issue_warp] == WST_BUSY);
  // At most one warp granted, and only one that asked (R7)
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~ready) == '0));
  // Nothing ready means no issue next cycle (R8)
  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (ready == '0) |=> !issue_valid);
  // Any ready warp yields an issue next cycle (R9)
  assert_ready_issues_R9: assert property (@(posedge clk) disable iff (rst)
    (ready != '0) |=> issue_valid);
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 4;
  localparam int NT  = 4;
  localparam int PCW = 16;
  localparam int WW  = $clog2(NW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic launch_valid = 0, wb_valid = 0, wb_exit = 0, mem_valid = 0, refill_valid = 0;
  logic [WW-1:0] launch_warp = '0, wb_warp = '0, mem_warp = '0, refill_warp = '0;
  logic [PCW-1:0] launch_pc = '0, wb_pc = '0, mem_pc = '0;
  logic [NT-1:0] mem_hit_mask = '0;
  logic issue_valid;
  logic [WW-1:0] issue_warp;
  logic [PCW-1:0] issue_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .THREADS(NT), .PC_W(PCW)) uut (
    .clk(clk), .rst(rst),
    .launch_valid(launch_valid), .launch_warp(launch_warp), .launch_pc(launch_pc),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_pc(wb_pc), .wb_exit(wb_exit),
    .mem_valid(mem_valid), .mem_warp(mem_warp), .mem_hit_mask(mem_hit_mask), .mem_pc(mem_pc),
    .refill_valid(refill_valid), .refill_warp(refill_warp),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pc(issue_pc)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    launch_valid = 0; wb_valid = 0; wb_exit = 0; mem_valid = 0; refill_valid = 0;
  endtask

  task automatic check_issue(input int w, input int pc, input string req);
    checks++;
    if (!issue_valid || issue_warp != WW'(w) || issue_pc != PCW'(pc)) begin
      errors++;
      $display("FAIL %s: got valid=%0b warp=%0d pc=%h, expected valid=1 warp=%0d pc=%h",
               req, issue_valid, issue_warp, issue_pc, w, pc);
    end
  endtask

  task automatic check_none(input string req);
    checks++;
    if (issue_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: got valid=%0b warp=%0d, expected valid=0", req, issue_valid, issue_warp);
    end
  endtask

  task automatic do_launch(input int w, input int pc);
    launch_valid = 1; launch_warp = WW'(w); launch_pc = PCW'(pc);
    cyc(); clear_inputs();
  endtask

  task automatic do_wb(input int w, input int pc, input bit ex);
    wb_valid = 1; wb_warp = WW'(w); wb_pc = PCW'(pc); wb_exit = ex;
    cyc(); clear_inputs();
  endtask

  task automatic do_mem(input int w, input int pc, input logic [NT-1:0] mask);
    mem_valid = 1; mem_warp = WW'(w); mem_pc = PCW'(pc); mem_hit_mask = mask;
    cyc(); clear_inputs();
  endtask

  task automatic do_refill(input int w);
    refill_valid = 1; refill_warp = WW'(w);
    cyc(); clear_inputs();
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) cyc();
    check_none("R1 during reset");
    rst = 0;
    repeat (3) begin
      cyc();
      check_none("R1 idle after reset");
    end
  endtask

  task automatic test_launch_wb();
    do_launch(2, 'h100);
    cyc(); check_issue(2, 'h100, "R2 launch issue");
    cyc(); check_none("R3 single in flight");
    cyc(); check_none("R8 nothing ready");
    do_launch(2, 'h999);
    cyc(); check_none("R2 launch to busy warp ignored");
    do_wb(2, 'h104, 0);
    cyc(); check_issue(2, 'h104, "R4 writeback resumes");
    do_wb(2, 'h0, 1);
    cyc(); check_none("R4 exit returns idle");
    do_launch(2, 'h200);
    cyc(); check_issue(2, 'h200, "R2 relaunch after exit");
    do_wb(2, 'h0, 1);
    cyc();
  endtask

  task automatic test_memory();
    do_launch(1, 'h10);
    cyc(); check_issue(1, 'h10, "R2 launch w1");
    do_mem(1, 'h14, 4'b1111);
    cyc(); check_issue(1, 'h14, "R5 all hit resumes");
    do_mem(1, 'h18, 4'b1011);
    repeat (3) begin
      cyc(); check_none("R5 miss parks warp");
    end
    do_refill(3);
    cyc(); check_none("R6 refill to idle warp ignored");
    cyc(); check_none("R6 refill to idle warp ignored");
    do_refill(1);
    check_none("R9 registered issue after refill");
    cyc(); check_issue(1, 'h18, "R6 refill wakes parked warp");
    do_wb(1, 'h0, 1);
    cyc(); check_none("R4 exit w1");
  endtask

  task automatic test_round_robin();
    do_launch(3, 'h30);
    cyc(); check_issue(3, 'h30, "R2 launch w3");
    do_launch(2, 'h20);
    cyc(); check_issue(2, 'h20, "R2 launch w2");
    do_mem(3, 'h34, 4'b0111);
    do_launch(1, 'h40);
    cyc(); check_issue(1, 'h40, "R2 launch w1");
    launch_valid = 1; launch_warp = 2'd0; launch_pc = 'h50;
    wb_valid = 1; wb_warp = 2'd1; wb_pc = 'h44; wb_exit = 0;
    mem_valid = 1; mem_warp = 2'd2; mem_pc = 'h24; mem_hit_mask = 4'b1111;
    refill_valid = 1; refill_warp = 2'd3;
    cyc(); clear_inputs();
    cyc(); check_issue(2, 'h24, "R7 first after last issued");
    cyc(); check_issue(3, 'h34, "R7 second in rotation");
    cyc(); check_issue(0, 'h50, "R7 wraparound");
    cyc(); check_issue(1, 'h44, "R7 last in rotation");
    cyc(); check_none("R8 all busy");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cyc();
    test_reset();
    test_launch_wb();
    test_memory();
    test_round_robin();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end
endmodule